// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block gathers every reset request in a small system into one system reset and remembers which request caused the most recent reset. The requests come from four places: a power-on reset, an active-low external reset pin, a supply-voltage monitor comparator, and a missing-clock timeout. The pin and the comparator are brought into the clock domain through flop synchronizers. The power-on reset asserts the system reset asynchronously. Every release is synchronous to the clock.

Software reaches two byte-wide registers through a simple write strobe, a one-bit register select and a combinational read port. Register 0 controls the supply monitor: enable, live supply status and threshold level. Register 1 holds one cause flag per source, plus the select bits that allow the supply monitor and the missing-clock timeout to cause a reset. The supply monitor resets the system only when it is both enabled and selected. At each reset exit the flags are rewritten so that exactly one flag names the cause. The threshold-level bit is also driven out to the analog monitor.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1. After `por_n` rises, `sys_rst` falls on a clock edge. Register 0 then reads 8'hC0 (enable 1, level 0, status 1 with the supply above threshold), and register 1 reads 8'h08, where bit 3 is the power-on flag and both select bits are 0.
- R2: When `ext_rst_n` is held low, `sys_rst` rises within three clock edges, after the two-flop synchronizer. Once the pin is high again, `sys_rst` falls on a clock edge and register 1 reads 8'h01 (bit 0 is the pin flag).
- R3: Register 0 has bit 7 = monitor enable (read/write), bit 6 = synchronized supply status (read-only; 1 means above threshold, 0 means at or below it) and bit 5 = level select (read/write; 0 selects the low threshold, 1 the high threshold). Bits 4..0 read 0 and ignore writes. `vmon_level` equals bit 5.
- R4: The supply monitor requests a reset only while its enable (register 0 bit 7) and its select (register 1 bit 4) are both 1 and the supply is at or below threshold. The reset is held for as long as that stays true. At exit, register 1 reads 8'h02 (bit 1 is the supply-monitor flag).
- R5: A missing-clock timeout request resets the system only while register 1 bit 5 (missing-clock enable) is 1. At exit, register 1 reads 8'h04 (bit 2 is the missing-clock flag). With bit 5 at 0, a timeout has no effect.
- R6: Writes to register 1 bits 3..0 never change the flags. At every reset exit exactly one flag is set, and it names the cause.
- R7: A reset that does not come from power-on leaves the monitor enable and level bits unchanged. Register writes made while `sys_rst` is 1 are ignored.
- R8: At every reset exit, both select bits in register 1 (bits 4 and 5) are cleared.
- R9: When several sources request a reset in the same cycle, the recorded cause follows this priority: supply monitor, then external pin, then missing clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| vmon_above | input | 1 | Supply comparator: 1 while the supply is above threshold |
| mcd_timeout | input | 1 | Missing-clock timeout request, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = monitor control, 1 = reset source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| sys_rst | output | 1 | System reset, active high |
| vmon_level | output | 1 | Threshold select to the analog monitor |

## Verification
Each source causes a reset on its own, and each exit value of register 1 shows that source's flag alone and both select bits cleared. The supply comparator is also driven low with the enable or the select missing, and the missing-clock timeout is pulsed with its enable off. These cases show that the gating terms, not the raw inputs, start a reset. Two collisions, supply monitor against missing clock and pin against missing clock, are lined up to reach the capture edge in the same cycle, which exercises the priority order. Register writes of all-ones patterns, and writes made during a held pin reset, show which bits are storage, which are read-only, and which are protected while the reset is active.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int REG_W = 8;

  // monitor control register fields
  localparam int MC_EN_BIT   = 7;
  localparam int MC_STAT_BIT = 6;
  localparam int MC_LVL_BIT  = 5;

  // reset source register fields
  localparam int NUM_FLAGS   = 4;
  localparam int RS_VSEL_BIT = 4;
  localparam int RS_MEN_BIT  = 5;

  // cause code doubles as flag bit index
  typedef enum logic [1:0] {
    CAUSE_PIN  = 2'd0,
    CAUSE_VMON = 2'd1,
    CAUSE_MCD  = 2'd2,
    CAUSE_POR  = 2'd3
  } cause_e;

  // fixed priority: supply monitor, pin, missing clock
  function automatic cause_e pick_cause(input logic vm, input logic pin, input logic mcd);
    cause_e c;
    if (vm)       c = CAUSE_VMON;
    else if (pin) c = CAUSE_PIN;
    else if (mcd) c = CAUSE_MCD;
    else          c = CAUSE_POR;
    return c;
  endfunction

  function automatic logic [NUM_FLAGS-1:0] cause_flags(input cause_e c);
    logic [NUM_FLAGS-1:0] f;
    f = '0;
    f[c] = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsc_arbiter.sv
module rsc_arbiter
  import rsc_pkg::*;
(
  input  logic   vmon_req,
  input  logic   pin_req,
  input  logic   mcd_req,
  output logic   any_req,
  output cause_e cause
);
  assign any_req = vmon_req | pin_req | mcd_req;
  assign cause   = pick_cause(vmon_req, pin_req, mcd_req);
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 wr_en,
  input  logic                 sel,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 exit_pulse,
  input  logic [NUM_FLAGS-1:0] exit_flags,
  input  logic                 supply_above,
  output logic [REG_W-1:0]     rdata,
  output logic                 vmon_en,
  output logic                 vmon_lvl,
  output logic                 vmon_sel,
  output logic                 mcd_en,
  output logic [NUM_FLAGS-1:0] flag_q
);
  logic [REG_W-1:0] mc_view;
  logic [REG_W-1:0] rs_view;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      vmon_en  <= 1'b1;
      vmon_lvl <= 1'b0;
    end else if (wr_en && !sel) begin
      vmon_en  <= wdata[MC_EN_BIT];
      vmon_lvl <= wdata[MC_LVL_BIT];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      vmon_sel <= 1'b0;
      mcd_en   <= 1'b0;
      flag_q   <= '0;
    end else if (exit_pulse) begin
      vmon_sel <= 1'b0;
      mcd_en   <= 1'b0;
      flag_q   <= exit_flags;
    end else if (wr_en && sel) begin
      vmon_sel <= wdata[RS_VSEL_BIT];
      mcd_en   <= wdata[RS_MEN_BIT];
    end
  end

  always_comb begin
    mc_view              = '0;
    mc_view[MC_EN_BIT]   = vmon_en;
    mc_view[MC_STAT_BIT] = supply_above;
    mc_view[MC_LVL_BIT]  = vmon_lvl;
    rs_view              = '0;
    rs_view[NUM_FLAGS-1:0] = flag_q;
    rs_view[RS_VSEL_BIT] = vmon_sel;
    rs_view[RS_MEN_BIT]  = mcd_en;
  end

  assign rdata = sel ? rs_view : mc_view;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             vmon_above,
  input  logic             mcd_timeout,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sys_rst,
  output logic             vmon_level
);
  logic                 pin_s;
  logic                 above_s;
  logic                 vmon_en, vmon_lvl, vmon_sel, mcd_en;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 vmon_req, pin_req, mcd_req, any_req;
  cause_e               req_cause;
  cause_e               cause_q;
  logic                 entry_evt;
  logic                 exit_evt;
  logic                 wr_ok;

  rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(por_n), .d(ext_rst_n), .q(pin_s)
  );

  rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_vmon_sync (
    .clk(clk), .arst_n(por_n), .d(vmon_above), .q(above_s)
  );

  assign vmon_req = vmon_en & vmon_sel & ~above_s;
  assign pin_req  = ~pin_s;
  assign mcd_req  = mcd_en & mcd_timeout;

  rsc_arbiter u_arb (
    .vmon_req(vmon_req), .pin_req(pin_req), .mcd_req(mcd_req),
    .any_req(any_req), .cause(req_cause)
  );

  assign entry_evt = !sys_rst && any_req;
  assign exit_evt  = sys_rst && !any_req;
  assign wr_ok     = reg_wr && !sys_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sys_rst <= 1'b1;
      cause_q <= CAUSE_POR;
    end else begin
      sys_rst <= any_req;
      if (entry_evt) cause_q <= req_cause;
    end
  end

  rsc_regs u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_ok), .sel(reg_sel), .wdata(reg_wdata),
    .exit_pulse(exit_evt), .exit_flags(cause_flags(cause_q)),
    .supply_above(above_s), .rdata(reg_rdata),
    .vmon_en(vmon_en), .vmon_lvl(vmon_lvl), .vmon_sel(vmon_sel),
    .mcd_en(mcd_en), .flag_q(flag_q)
  );

  assign vmon_level = vmon_lvl;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
  import rsc_pkg::*;
(
  input logic                 clk,
  input logic                 por_n,
  input logic                 sys_rst,
  input logic                 reg_sel,
  input logic [REG_W-1:0]     reg_rdata,
  input logic                 vmon_level,
  input logic                 mcd_timeout,
  input logic                 pin_s,
  input logic                 vmon_en,
  input logic                 vmon_lvl,
  input logic                 vmon_sel,
  input logic                 mcd_en,
  input logic [NUM_FLAGS-1:0] flag_q
);
  // R6
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> $onehot(flag_q));

  // R8
  sel_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (!vmon_sel && !mcd_en));

  // R4
  vmon_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !(vmon_en && vmon_sel) && pin_s && !(mcd_en && mcd_timeout)) |=> !sys_rst);

  // R2
  pin_assert_chk: assert property (@(posedge clk) disable iff (!por_n)
    !pin_s |=> sys_rst);

  // R7
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && $past(sys_rst)) |-> ($stable(vmon_en) && $stable(vmon_lvl)));

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
    !reg_sel |-> (reg_rdata[4:0] == 5'd0 && reg_rdata[MC_LVL_BIT] == vmon_level));
endmodule

bind rst_src_ctrl rsc_checker u_rsc_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .vmon_level(vmon_level), .mcd_timeout(mcd_timeout),
  .pin_s(pin_s), .vmon_en(vmon_en), .vmon_lvl(vmon_lvl), .vmon_sel(vmon_sel),
  .mcd_en(mcd_en), .flag_q(flag_q)
);

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       vmon_above = 1'b1;
  logic       mcd_timeout = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b1;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst;
  logic       vmon_level;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_rst = 1'b0;

  always #4 clk = ~clk;

  rst_src_ctrl u_rst_src_ctrl (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .vmon_above(vmon_above),
    .mcd_timeout(mcd_timeout), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst),
    .vmon_level(vmon_level)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard driver side: expected register 1 value at the next reset exit
  task automatic expect_exit(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: compares at each release of sys_rst
  always @(posedge clk) begin
    #2;
    if (prev_rst && !sys_rst) begin
      if (exp_q.size() == 0) check("R6 unexpected reset exit", reg_rdata, 8'hxx);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
    prev_rst = sys_rst;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b1;
  endtask

  task automatic rd(input logic s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_sel = s;
    #1;
    check(tag, reg_rdata, exp);
    reg_sel = 1'b1;
  endtask

  task automatic wait_exit(input string tag);
    int n = 0;
    while (sys_rst && n < 40) begin @(negedge clk); n++; end
    check(tag, {7'd0, sys_rst}, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 power-on
    cyc(3);
    check("R1 sys_rst during por", {7'd0, sys_rst}, 8'h01);
    expect_exit(8'h08, "R1 por exit flags");
    por_n = 1'b1;
    wait_exit("R1 release");
    rd(1'b0, 8'hC0, "R1 monitor ctrl default");
    check("R1 level out", {7'd0, vmon_level}, 8'h00);

    // R3 layout and ignored low bits
    wr(1'b0, 8'h3F);
    rd(1'b0, 8'h60, "R3 writable fields only");
    check("R3 level out high", {7'd0, vmon_level}, 8'h01);

    // R2 pin reset, R7 writes ignored during reset and cfg kept
    expect_exit(8'h01, "R2 pin exit flags");
    @(negedge clk); ext_rst_n = 1'b0;
    cyc(3);
    check("R2 asserted after sync", {7'd0, sys_rst}, 8'h01);
    wr(1'b0, 8'h80);
    ext_rst_n = 1'b1;
    wait_exit("R2 release");
    rd(1'b0, 8'h60, "R7 cfg kept and write in reset ignored");

    // R4 gating
    wr(1'b0, 8'h80);
    vmon_above = 1'b0;
    cyc(4);
    rd(1'b0, 8'h80, "R3 status low");
    check("R4 enabled not selected", {7'd0, sys_rst}, 8'h00);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h10);
    cyc(4);
    check("R4 selected not enabled", {7'd0, sys_rst}, 8'h00);
    rd(1'b1, 8'h11, "R4 select stored");
    expect_exit(8'h02, "R4 vmon exit flags");
    wr(1'b0, 8'h80);
    cyc(5);
    check("R4 held while below", {7'd0, sys_rst}, 8'h01);
    vmon_above = 1'b1;
    wait_exit("R4 release");
    rd(1'b1, 8'h02, "R8 selects cleared");

    // R6 flags not writable
    wr(1'b1, 8'h0F);
    rd(1'b1, 8'h02, "R6 flag write ignored");
    wr(1'b1, 8'h3D);
    rd(1'b1, 8'h32, "R6 flags kept selects set");

    // R5 missing clock
    expect_exit(8'h04, "R5 mcd exit flags");
    @(negedge clk); mcd_timeout = 1'b1;
    @(negedge clk); mcd_timeout = 1'b0;
    wait_exit("R5 release");
    @(negedge clk); mcd_timeout = 1'b1;
    @(negedge clk); mcd_timeout = 1'b0;
    cyc(4);
    check("R5 disabled timeout ignored", {7'd0, sys_rst}, 8'h00);
    rd(1'b1, 8'h04, "R5 flags unchanged");

    // R9 supply monitor over missing clock
    vmon_above = 1'b0;
    cyc(4);
    expect_exit(8'h02, "R9 vmon beats mcd");
    @(negedge clk);
    reg_sel = 1'b1; reg_wdata = 8'h30; reg_wr = 1'b1; mcd_timeout = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    mcd_timeout = 1'b0; vmon_above = 1'b1;
    wait_exit("R9 release a");

    // R9 pin over missing clock
    wr(1'b1, 8'h20);
    expect_exit(8'h01, "R9 pin beats mcd");
    @(negedge clk); ext_rst_n = 1'b0;
    cyc(2);
    mcd_timeout = 1'b1;
    @(negedge clk); mcd_timeout = 1'b0;
    ext_rst_n = 1'b1;
    wait_exit("R9 release b");

    cyc(3);
    check("R6 all exits seen", exp_q.size()[7:0], 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule